// File: doc/BRIEF.md
# Conditional Trace Capture Buffer

This block records bus activity into a ring of 1023 frames so that the most recent history can be read back after a run. On any clock it can take one frame from one of four sources: the address phase of a bus cycle, the data phase of a bus cycle, a clock in which the instruction queue is active, or an emulation stop event. Each frame packs the 20-bit address/data value, bus status, queue status, queue depth, byte-high-enable, a frame type and a resume marker into a 32-bit word.

Capture can be on, off, or conditional. In conditional mode, match pulses from external tracepoint comparators turn capture on and off. A mode write can set the conditional start state. A mode write also arms a clear that takes effect at the next emulation entry. A separate request empties the buffer at once. During single-step, memory reads to the interrupt-vector bytes at addresses 8 to 11 are kept out of the buffer. A combinational read port returns any slot by index. The block also reports the oldest slot, the newest slot and the fill count.

Top module: `trace_capture_buf`

## Requirements
- R1: The ring holds 1023 frames. When it is full, each new frame overwrites the oldest one, `fill_cnt` stays at 1023, and `oldest_idx` equals the slot that will be written next.
- R2: At most one frame is written per clock. When several strobes are high together, the source is chosen in this order: stop (type 3), then address (type 0), then data (type 1), then queue (type 2).
- R3: The frame layout is: bit 31 byte-high-enable (active low), bit 30 marker, bits 29:28 type, bits 27:25 queue depth, bits 24:23 queue status, bits 22:20 bus status, bits 19:0 address/data.
- R4: `mode_sel` 0 turns capture off and 1 turns it on unconditionally. Code 3 behaves as off. In the off mode no frame is written, and match pulses are ignored.
- R5: With `mode_sel` 2 (conditional), `on_hit` turns capture on and `off_hit` turns it off. If both are high in one clock, off wins. A change affects frames from the next clock on, so a frame in the same clock as the pulse uses the old state. In the on and off modes, match pulses have no effect.
- R6: On a conditional mode write, `init_sel` 1 starts capture on, 2 starts it off, and 0 or 3 keeps the current capture state.
- R7: The marker bit is 1 in the first frame written after capture went from on to off. It is 0 in every other frame.
- R8: `clr_req` empties the buffer at once: the fill becomes 0, the next write slot becomes 0, any frame in the same clock is dropped, and the marker state is cleared.
- R9: Every mode write arms a pending clear. The next `emu_entry` with a clear armed empties the buffer, as in R8, and disarms it. Frames that arrive before that entry are still stored. An `emu_entry` with nothing armed changes nothing.
- R10: While `single_step` is high, a bus cycle whose address phase shows memory-read status 5 and an address from 8 to 11 writes neither its address frame nor its data frame. The mask is latched at the address strobe.
- R11: After reset, capture is on unconditionally, the buffer is empty, `oldest_idx` is 0 and `newest_idx` is 1022.
- R12: `rd_frame` shows the stored frame of slot `rd_idx` in the same cycle. `newest_idx` is the slot before the next write slot, modulo 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_stb | input | 1 | Address phase valid |
| data_stb | input | 1 | Data phase valid |
| queue_stb | input | 1 | Instruction queue active this clock |
| stop_stb | input | 1 | Emulation stop event |
| bus_ad | input | 20 | Address or data value |
| bus_sts | input | 3 | Bus status code |
| queue_sts | input | 2 | Queue status code |
| queue_depth | input | 3 | Bytes held in the queue |
| bhe_n | input | 1 | Byte-high-enable, active low |
| on_hit | input | 1 | Tracepoint match: turn capture on |
| off_hit | input | 1 | Tracepoint match: turn capture off |
| single_step | input | 1 | Single-step run active |
| mode_wr | input | 1 | Write the capture mode |
| mode_sel | input | 2 | Mode: 0 off, 1 on, 2 conditional |
| init_sel | input | 2 | Conditional start: 1 on, 2 off, else keep |
| emu_entry | input | 1 | Emulation entry pulse |
| clr_req | input | 1 | Immediate clear request |
| rd_idx | input | 10 | Slot to read |
| rd_frame | output | 32 | Frame stored in slot `rd_idx` |
| oldest_idx | output | 10 | Slot of the oldest stored frame |
| newest_idx | output | 10 | Slot of the newest stored frame |
| fill_cnt | output | 10 | Number of stored frames |

## Verification
Directed sequences come first. All four strobes together and then smaller subsets expose the source priority. Reads to masked and neighbouring addresses, with and without single-step, show whether the mask is bounded correctly. Match pulses that coincide with frames show whether a state change takes effect one clock late. A run of 1100 queue frames forces wraparound of the odd-sized ring. A long random mix of strobes, pulses, mode writes, entries and clears is then compared every clock against a queue-based model. This mix finds ordering faults between clear, write and marker updates that the directed cases miss.

// File: rtl/trace_pkg.sv
`timescale 1ns/1ps
package trace_pkg;

    localparam int unsigned AD_W = 20;
    localparam int unsigned BS_W = 3;
    localparam int unsigned QS_W = 2;
    localparam int unsigned QD_W = 3;

    typedef enum logic [1:0] {
        FT_ADDR  = 2'd0,
        FT_DATA  = 2'd1,
        FT_QUEUE = 2'd2,
        FT_STOP  = 2'd3
    } ftype_e;

    typedef enum logic [1:0] {
        MD_OFF  = 2'd0,
        MD_ON   = 2'd1,
        MD_COND = 2'd2,
        MD_RSVD = 2'd3
    } mode_e;

    typedef struct packed {
        logic            bhe_n;
        logic            mark;
        ftype_e          ftype;
        logic [QD_W-1:0] qdepth;
        logic [QS_W-1:0] qsts;
        logic [BS_W-1:0] bsts;
        logic [AD_W-1:0] ad;
    } frame_t;

    localparam int unsigned FRAME_W = $bits(frame_t);

endpackage

// File: rtl/trace_gate.sv
`timescale 1ns/1ps
module trace_gate
    import trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_sel,
    input  logic [1:0] init_sel,
    input  logic       on_hit,
    input  logic       off_hit,
    input  logic       emu_entry,
    input  logic       clr_req,
    input  logic       frame_wr,
    output logic       cap_on,
    output logic       mark,
    output logic       clear
);

    typedef struct packed {
        mode_e mode;
        logic  cap;
        logic  gap;
        logic  pend;
    } gate_st_t;

    gate_st_t s_d, s_q;

    assign clear  = clr_req | (emu_entry & s_q.pend);
    assign cap_on = s_q.cap;
    assign mark   = s_q.gap;

    always_comb begin
        s_d = s_q;
        if (frame_wr) begin
            s_d.gap = 1'b0;
        end
        if (clear) begin
            s_d.gap  = 1'b0;
            s_d.pend = 1'b0;
        end
        if (mode_wr) begin
            s_d.mode = mode_e'(mode_sel);
            s_d.pend = 1'b1;
            unique case (mode_e'(mode_sel))
                MD_ON:   s_d.cap = 1'b1;
                MD_COND: begin
                    if (init_sel == 2'd1) begin
                        s_d.cap = 1'b1;
                    end else if (init_sel == 2'd2) begin
                        s_d.cap = 1'b0;
                    end
                end
                default: s_d.cap = 1'b0;
            endcase
        end else if (s_q.mode == MD_COND) begin
            if (off_hit) begin
                s_d.cap = 1'b0;
            end else if (on_hit) begin
                s_d.cap = 1'b1;
            end
        end
        if (s_q.cap && !s_d.cap) begin
            s_d.gap = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= MD_ON;
            s_q.cap  <= 1'b1;
            s_q.gap  <= 1'b0;
            s_q.pend <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_OFF && !mode_wr) |=> !cap_on) else $error("off mode captured"); // R4
    AST_ON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_ON && !mode_wr) |=> cap_on) else $error("on mode dropped"); // R5
    AST_GAP_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_COND && cap_on && off_hit && !mode_wr) |=> (mark && !cap_on)) else $error("gap not flagged"); // R7
    AST_ENTRY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_entry && s_q.pend && !mode_wr) |=> !s_q.pend) else $error("clear stayed armed"); // R9

endmodule

// File: rtl/trace_fmt.sv
`timescale 1ns/1ps
module trace_fmt
    import trace_pkg::*;
#(
    parameter int unsigned MASK_LO  = 8,
    parameter int unsigned MASK_HI  = 11,
    parameter logic [BS_W-1:0] READ_STS = 3'd5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_stb,
    input  logic            data_stb,
    input  logic            queue_stb,
    input  logic            stop_stb,
    input  logic [AD_W-1:0] bus_ad,
    input  logic [BS_W-1:0] bus_sts,
    input  logic [QS_W-1:0] queue_sts,
    input  logic [QD_W-1:0] queue_depth,
    input  logic            bhe_n,
    input  logic            single_step,
    input  logic            mark,
    output logic            frm_valid,
    output frame_t          frame
);

    typedef struct packed {
        logic masked;
    } fmt_st_t;

    fmt_st_t s_d, s_q;
    logic    hit_mask;

    assign hit_mask = single_step && (bus_sts == READ_STS)
                    && (bus_ad >= AD_W'(MASK_LO)) && (bus_ad <= AD_W'(MASK_HI));

    always_comb begin
        s_d          = s_q;
        frm_valid    = 1'b0;
        frame.bhe_n  = bhe_n;
        frame.mark   = mark;
        frame.ftype  = FT_QUEUE;
        frame.qdepth = queue_depth;
        frame.qsts   = queue_sts;
        frame.bsts   = bus_sts;
        frame.ad     = bus_ad;
        if (addr_stb) begin
            s_d.masked = hit_mask;
        end
        if (stop_stb) begin
            frame.ftype = FT_STOP;
            frm_valid   = 1'b1;
        end else if (addr_stb) begin
            frame.ftype = FT_ADDR;
            frm_valid   = !hit_mask;
        end else if (data_stb) begin
            frame.ftype = FT_DATA;
            frm_valid   = !s_q.masked;
        end else if (queue_stb) begin
            frame.ftype = FT_QUEUE;
            frm_valid   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.masked <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_MASK_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_stb && !stop_stb && single_step && bus_sts == READ_STS
         && bus_ad >= AD_W'(MASK_LO) && bus_ad <= AD_W'(MASK_HI))
        |=> (!(data_stb && !addr_stb && !stop_stb) || !frm_valid)) else $error("masked data kept"); // R10
    AST_SOURCE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (addr_stb || data_stb || queue_stb || stop_stb)) else $error("frame without strobe"); // R2

endmodule

// File: rtl/trace_ring.sv
`timescale 1ns/1ps
module trace_ring
    import trace_pkg::*;
#(
    parameter int unsigned DEPTH = 1023,
    parameter int unsigned IDX_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             clear,
    input  frame_t           wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output frame_t           rd_data,
    output logic [IDX_W-1:0] oldest_idx,
    output logic [IDX_W-1:0] newest_idx,
    output logic [CNT_W-1:0] fill_cnt
);

    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [IDX_W-1:0] wp;
        logic [CNT_W-1:0] cnt;
    } ring_st_t;

    ring_st_t s_d, s_q;
    frame_t   mem [DEPTH];
    logic [IDX_W:0] wp_ext;
    logic [IDX_W:0] cnt_ext;

    assign wp_ext  = {1'b0, s_q.wp};
    assign cnt_ext = (IDX_W + 1)'(s_q.cnt);

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.wp  = '0;
            s_d.cnt = '0;
        end else if (wr) begin
            s_d.wp = (s_q.wp == LAST_SLOT) ? '0 : s_q.wp + 1'b1;
            if (s_q.cnt != FULL_CNT) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_comb begin
        if (s_q.cnt == FULL_CNT) begin
            oldest_idx = s_q.wp;
        end else if (wp_ext >= cnt_ext) begin
            oldest_idx = IDX_W'(wp_ext - cnt_ext);
        end else begin
            oldest_idx = IDX_W'(wp_ext + (IDX_W + 1)'(DEPTH) - cnt_ext);
        end
        newest_idx = (s_q.wp == '0) ? LAST_SLOT : s_q.wp - 1'b1;
        fill_cnt   = s_q.cnt;
        rd_data    = (rd_idx <= LAST_SLOT) ? mem[rd_idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (wr && !clear) begin
            mem[s_q.wp] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.wp  <= '0;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT) else $error("fill above depth"); // R1
    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clear && s_q.cnt != FULL_CNT) |=> (fill_cnt == $past(fill_cnt) + 1'b1)) else $error("fill step"); // R1
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == FULL_CNT && !clear) |=> (fill_cnt == FULL_CNT)) else $error("full dropped"); // R1
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill_cnt == '0 && newest_idx == LAST_SLOT)) else $error("clear incomplete"); // R8

endmodule

// File: rtl/trace_capture_buf.sv
`timescale 1ns/1ps
module trace_capture_buf
    import trace_pkg::*;
#(
    parameter int unsigned DEPTH    = 1023,
    parameter int unsigned MASK_LO  = 8,
    parameter int unsigned MASK_HI  = 11,
    parameter logic [2:0]  READ_STS = 3'd5,
    localparam int unsigned IDX_W   = $clog2(DEPTH),
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_stb,
    input  logic               data_stb,
    input  logic               queue_stb,
    input  logic               stop_stb,
    input  logic [AD_W-1:0]    bus_ad,
    input  logic [BS_W-1:0]    bus_sts,
    input  logic [QS_W-1:0]    queue_sts,
    input  logic [QD_W-1:0]    queue_depth,
    input  logic               bhe_n,
    input  logic               on_hit,
    input  logic               off_hit,
    input  logic               single_step,
    input  logic               mode_wr,
    input  logic [1:0]         mode_sel,
    input  logic [1:0]         init_sel,
    input  logic               emu_entry,
    input  logic               clr_req,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0] rd_frame,
    output logic [IDX_W-1:0]   oldest_idx,
    output logic [IDX_W-1:0]   newest_idx,
    output logic [CNT_W-1:0]   fill_cnt
);

    logic   cap_on;
    logic   mark;
    logic   clear;
    logic   frm_valid;
    logic   frame_wr;
    frame_t frame;
    frame_t rd_data;

    assign frame_wr = frm_valid & cap_on;
    assign rd_frame = rd_data;

    trace_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_sel  (mode_sel),
        .init_sel  (init_sel),
        .on_hit    (on_hit),
        .off_hit   (off_hit),
        .emu_entry (emu_entry),
        .clr_req   (clr_req),
        .frame_wr  (frame_wr),
        .cap_on    (cap_on),
        .mark      (mark),
        .clear     (clear)
    );

    trace_fmt #(
        .MASK_LO  (MASK_LO),
        .MASK_HI  (MASK_HI),
        .READ_STS (READ_STS)
    ) u_fmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_stb    (addr_stb),
        .data_stb    (data_stb),
        .queue_stb   (queue_stb),
        .stop_stb    (stop_stb),
        .bus_ad      (bus_ad),
        .bus_sts     (bus_sts),
        .queue_sts   (queue_sts),
        .queue_depth (queue_depth),
        .bhe_n       (bhe_n),
        .single_step (single_step),
        .mark        (mark),
        .frm_valid   (frm_valid),
        .frame       (frame)
    );

    trace_ring #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (frame_wr),
        .clear      (clear),
        .wdata      (frame),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .oldest_idx (oldest_idx),
        .newest_idx (newest_idx),
        .fill_cnt   (fill_cnt)
    );

    AST_CLEAR_DROPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && frm_valid) |=> (fill_cnt == '0)) else $error("frame kept on clear"); // R8

endmodule

// File: tb/trace_capture_buf_tb_top.sv
`timescale 1ns/1ps
module trace_capture_buf_tb_top;

    localparam int D = 1023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_stb = 0, data_stb = 0, queue_stb = 0, stop_stb = 0;
    logic [19:0] bus_ad = '0;
    logic [2:0]  bus_sts = '0;
    logic [1:0]  queue_sts = '0;
    logic [2:0]  queue_depth = '0;
    logic        bhe_n = 1'b1;
    logic        on_hit = 0, off_hit = 0, single_step = 0;
    logic        mode_wr = 0;
    logic [1:0]  mode_sel = '0, init_sel = '0;
    logic        emu_entry = 0, clr_req = 0;
    logic [9:0]  rd_idx = '0;
    logic [31:0] rd_frame;
    logic [9:0]  oldest_idx, newest_idx, fill_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    bit running = 0;

    trace_capture_buf dut_i (
        .clk(clk), .rst_n(rst_n),
        .addr_stb(addr_stb), .data_stb(data_stb), .queue_stb(queue_stb), .stop_stb(stop_stb),
        .bus_ad(bus_ad), .bus_sts(bus_sts), .queue_sts(queue_sts), .queue_depth(queue_depth),
        .bhe_n(bhe_n), .on_hit(on_hit), .off_hit(off_hit), .single_step(single_step),
        .mode_wr(mode_wr), .mode_sel(mode_sel), .init_sel(init_sel),
        .emu_entry(emu_entry), .clr_req(clr_req), .rd_idx(rd_idx),
        .rd_frame(rd_frame), .oldest_idx(oldest_idx), .newest_idx(newest_idx), .fill_cnt(fill_cnt)
    );

    always #2.5 clk = ~clk;

    // Reference model: slot queue plus stored words
    logic [31:0] m_mem [D];
    bit          m_live [D];
    int          m_slots [$];
    int          m_wslot;
    int          m_mode;
    bit          m_cap, m_gap, m_pend, m_masked;

    task automatic m_reset();
        m_slots.delete();
        m_wslot = 0; m_mode = 1; m_cap = 1; m_gap = 0; m_pend = 0; m_masked = 0;
        for (int i = 0; i < D; i++) m_live[i] = 0;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            bit clr, valid, wr, hitm, ncap;
            logic [1:0] ft;
            clr  = clr_req || (emu_entry && m_pend);
            hitm = single_step && bus_sts == 3'd5 && bus_ad >= 20'd8 && bus_ad <= 20'd11;
            valid = 0; ft = 2'd2;
            if (stop_stb) begin ft = 2'd3; valid = 1; end
            else if (addr_stb) begin ft = 2'd0; valid = !hitm; end
            else if (data_stb) begin ft = 2'd1; valid = !m_masked; end
            else if (queue_stb) begin ft = 2'd2; valid = 1; end
            wr = valid && m_cap;
            if (clr) begin
                m_slots.delete();
                m_wslot = 0;
                for (int i = 0; i < D; i++) m_live[i] = 0;
            end else if (wr) begin
                m_mem[m_wslot]  = {bhe_n, m_gap, ft, queue_depth, queue_sts, bus_sts, bus_ad};
                m_live[m_wslot] = 1;
                m_slots.push_back(m_wslot);
                if (m_slots.size() > D) void'(m_slots.pop_front());
                m_wslot = (m_wslot + 1) % D;
            end
            if (addr_stb) m_masked = hitm;
            ncap = m_cap;
            if (wr) m_gap = 0;
            if (clr) begin m_gap = 0; m_pend = 0; end
            if (mode_wr) begin
                m_mode = int'(mode_sel);
                m_pend = 1;
                if (mode_sel == 2'd1) ncap = 1;
                else if (mode_sel == 2'd2) begin
                    if (init_sel == 2'd1) ncap = 1;
                    else if (init_sel == 2'd2) ncap = 0;
                end else ncap = 0;
            end else if (m_mode == 2) begin
                if (off_hit) ncap = 0;
                else if (on_hit) ncap = 1;
            end
            if (m_cap && !ncap) m_gap = 1;
            m_cap = ncap;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int m_oldest();
        return (m_slots.size() == 0) ? m_wslot : m_slots[0];
    endfunction

    // Every-clock comparison of status outputs (R1, R12)
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk(fill_cnt == 10'(m_slots.size()), "R1 fill model", fill_cnt, m_slots.size());
            chk(oldest_idx == 10'(m_oldest()), "R1 oldest model", oldest_idx, m_oldest());
            chk(newest_idx == 10'((m_wslot + D - 1) % D), "R12 newest model", newest_idx, (m_wslot + D - 1) % D);
        end
    end

    task automatic go();
        @(negedge clk);
        addr_stb = 0; data_stb = 0; queue_stb = 0; stop_stb = 0;
        on_hit = 0; off_hit = 0; mode_wr = 0; emu_entry = 0; clr_req = 0;
    endtask

    task automatic rd_chk(input int idx, input string req);
        rd_idx = 10'(idx);
        #1;
        chk(rd_frame === m_mem[idx], req, rd_frame, m_mem[idx]);
    endtask

    task automatic set_mode(input logic [1:0] m, input logic [1:0] ini);
        mode_wr = 1; mode_sel = m; init_sel = ini; go();
    endtask

    task automatic qframe();
        queue_stb = 1; queue_depth = queue_depth + 3'd1; go();
    endtask

    task automatic addr_ph(input logic [19:0] a, input logic [2:0] s);
        addr_stb = 1; bus_ad = a; bus_sts = s; go();
    endtask

    task automatic data_ph(input logic [19:0] v, input logic [2:0] s);
        data_stb = 1; bus_ad = v; bus_sts = s; go();
    endtask

    task automatic full_readout(input string req);
        for (int i = 0; i < D; i++) if (m_live[i]) rd_chk(i, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        running = 1;
        @(negedge clk);
        // R11 reset state
        chk(fill_cnt == 0, "R11 fill", fill_cnt, 0);
        chk(oldest_idx == 0, "R11 oldest", oldest_idx, 0);
        chk(newest_idx == 10'd1022, "R11 newest", newest_idx, 1022);

        // R3 layout, R4 on after reset
        addr_stb = 1; bus_ad = 20'h12345; bus_sts = 3'd4; queue_sts = 2'd1; queue_depth = 3'd3; bhe_n = 1;
        go();
        chk(fill_cnt == 1, "R4 on captures", fill_cnt, 1);
        rd_idx = 0; #1;
        chk(rd_frame == 32'h86C12345, "R3 layout", rd_frame, 32'h86C12345);
        chk(newest_idx == 0, "R12 newest", newest_idx, 0);

        // R2 priority
        bhe_n = 0; queue_sts = 0; queue_depth = 0;
        addr_stb = 1; data_stb = 1; queue_stb = 1; stop_stb = 1; bus_ad = 20'hABCDE; bus_sts = 0; go();
        chk(fill_cnt == 2, "R2 one per clock", fill_cnt, 2);
        rd_idx = 1; #1; chk(rd_frame[29:28] == 2'd3, "R2 stop first", rd_frame[29:28], 3);
        addr_stb = 1; data_stb = 1; queue_stb = 1; go();
        rd_idx = 2; #1; chk(rd_frame[29:28] == 2'd0, "R2 addr second", rd_frame[29:28], 0);
        data_stb = 1; queue_stb = 1; go();
        rd_idx = 3; #1; chk(rd_frame[29:28] == 2'd1, "R2 data third", rd_frame[29:28], 1);
        qframe();
        rd_idx = 4; #1; chk(rd_frame[29:28] == 2'd2, "R2 queue last", rd_frame[29:28], 2);

        // R10 single-step mask
        single_step = 1;
        addr_ph(20'h00009, 3'd5); data_ph(20'h0000F, 3'd5);
        chk(fill_cnt == 5, "R10 masked read", fill_cnt, 5);
        addr_ph(20'h0000C, 3'd5); data_ph(20'h00001, 3'd5);
        chk(fill_cnt == 7, "R10 above range kept", fill_cnt, 7);
        addr_ph(20'h00008, 3'd6);
        chk(fill_cnt == 8, "R10 write kept", fill_cnt, 8);
        single_step = 0;
        addr_ph(20'h00009, 3'd5);
        chk(fill_cnt == 9, "R10 no step kept", fill_cnt, 9);

        // R6 / R7 / R5 conditional
        set_mode(2'd2, 2'd2);
        qframe(); chk(fill_cnt == 9, "R6 init off", fill_cnt, 9);
        on_hit = 1; go();
        qframe(); chk(fill_cnt == 10, "R5 on hit", fill_cnt, 10);
        rd_idx = 9; #1; chk(rd_frame[30] == 1'b1, "R7 marker set", rd_frame[30], 1);
        qframe();
        rd_idx = 10; #1; chk(rd_frame[30] == 1'b0, "R7 marker once", rd_frame[30], 0);
        off_hit = 1; qframe(); chk(fill_cnt == 12, "R5 off late", fill_cnt, 12);
        qframe(); chk(fill_cnt == 12, "R5 off effective", fill_cnt, 12);
        on_hit = 1; qframe(); chk(fill_cnt == 12, "R5 on late", fill_cnt, 12);
        qframe(); chk(fill_cnt == 13, "R5 on effective", fill_cnt, 13);
        on_hit = 1; off_hit = 1; go();
        qframe(); chk(fill_cnt == 13, "R5 off wins", fill_cnt, 13);
        set_mode(2'd2, 2'd0);
        qframe(); chk(fill_cnt == 13, "R6 keep", fill_cnt, 13);
        set_mode(2'd2, 2'd1);
        qframe(); chk(fill_cnt == 14, "R6 init on", fill_cnt, 14);
        set_mode(2'd1, 2'd0);
        off_hit = 1; go();
        qframe(); chk(fill_cnt == 15, "R5 hits ignored in on", fill_cnt, 15);
        full_readout("R12 readout");

        // R9 deferred clear
        emu_entry = 1; go();
        chk(fill_cnt == 0, "R9 entry clears", fill_cnt, 0);
        qframe(); qframe();
        emu_entry = 1; go();
        chk(fill_cnt == 2, "R9 unarmed entry", fill_cnt, 2);

        // R8 immediate clear drops same-clock frame
        clr_req = 1; queue_stb = 1; go();
        chk(fill_cnt == 0, "R8 clear", fill_cnt, 0);
        chk(oldest_idx == 0, "R8 slot zero", oldest_idx, 0);

        // R4 off mode
        set_mode(2'd0, 2'd1);
        repeat (4) qframe();
        on_hit = 1; go(); qframe();
        chk(fill_cnt == 0, "R4 off mode", fill_cnt, 0);
        set_mode(2'd3, 2'd1);
        qframe(); chk(fill_cnt == 0, "R4 code 3 off", fill_cnt, 0);

        // R1 wraparound
        set_mode(2'd1, 2'd0);
        emu_entry = 1; go();
        for (int i = 0; i < 1100; i++) qframe();
        chk(fill_cnt == 10'd1023, "R1 full", fill_cnt, 1023);
        chk(oldest_idx == 10'd77, "R1 oldest wraps", oldest_idx, 77);
        chk(newest_idx == 10'd76, "R1 newest wraps", newest_idx, 76);
        full_readout("R1 overwrite");

        // Random mix against the model
        for (int c = 0; c < 6000; c++) begin
            int r;
            r = $urandom % 6;
            addr_stb  = ($urandom % 3) == 0;
            data_stb  = ($urandom % 3) == 0;
            queue_stb = ($urandom % 2) == 0;
            stop_stb  = ($urandom % 40) == 0;
            bus_ad    = (r < 3) ? 20'(8 + ($urandom % 5)) : 20'($urandom);
            bus_sts   = ($urandom % 2) ? 3'd5 : 3'($urandom);
            queue_sts = 2'($urandom);
            queue_depth = 3'($urandom);
            bhe_n     = 1'($urandom);
            on_hit    = ($urandom % 8) == 0;
            off_hit   = ($urandom % 9) == 0;
            mode_wr   = ($urandom % 90) == 0;
            mode_sel  = 2'($urandom % 3);
            init_sel  = 2'($urandom);
            emu_entry = ($urandom % 70) == 0;
            clr_req   = ($urandom % 900) == 0;
            if (($urandom % 50) == 0) single_step = ~single_step;
            go();
        end
        full_readout("R12 random readout");

        running = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule